// File: doc/BRIEF.md
# ALU Operation Select Decoder

This block sits beside the main instruction decoder of a single-cycle processor. It chooses the operation that the 32-bit ALU performs. The main decoder looks only at the opcode. It emits a 3-bit operation class, and this block combines that class with the 6-bit function field of the instruction to form a 3-bit operation select for the ALU. Because the function field is decoded here and not in the main decoder, the main decoder's input space stays at 64 combinations and does not grow to several thousand.

For immediate, load, store and branch instructions, the operation class alone fixes the result: address addition, compare subtraction, or a logical OR. For register-register instructions, the main decoder sends the class value `100`, and the result comes from the low four bits of the function field. The output is a pure function of the two inputs. There is no clock and no state. Every input combination, including function codes that are not supported, gives a defined output.

Top module: `alu_ctl_dec`

## Requirements
- R1: Class `000` yields select `010` (add), whatever the function field holds.
- R2: Class `001` yields select `110` (subtract), whatever the function field holds.
- R3: Class `010` yields select `001` (OR), whatever the function field holds.
- R4: Classes `011`, `101`, `110` and `111` yield select `000`, whatever the function field holds.
- R5: Under class `100`, function `100000` yields `010` (add) and function `100010` yields `110` (subtract).
- R6: Under class `100`, function `100100` yields `000` (AND) and function `100101` yields `001` (OR).
- R7: Under class `100`, function `101010` yields `111` (set-less-than).
- R8: Under class `100`, function bits 5 and 4 have no effect on the select.
- R9: Under class `100`, any function code gives the following select. Bit 2 is set when function bits 2..0 equal `010`. Bit 1 is set when function bit 2 is 0. Bit 0 is set when function bits 3..0 equal `0101` or `1010`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| alu_class | input | 3 | Operation class from the main decoder; `100` marks a register-register instruction |
| fn_code | input | 6 | Function field of the instruction |
| alu_sel | output | 3 | Operation select for the ALU |

## Verification
The hardest cases to reach are the function codes that no instruction uses, and in particular codes whose upper two bits are not `10`. Directed tests on the five supported operations would never apply them, yet R8 and R9 define their results exactly. The stimulus therefore sweeps all 8 class values against all 64 function codes. Each output is compared with a reference model written as a case statement on function bits 2..0. A short table of named vectors first pins down the supported operations and a few aliased codes.

// File: rtl/alu_ctl_pkg.sv
// Package: shared widths and code values for the ALU operation select decoder.
// Assumes the class, function and select widths used by the main decoder.
package alu_ctl_pkg;
    localparam int CLASS_W = 3;
    localparam int FN_W    = 6;
    localparam int SEL_W   = 3;
    localparam int FN_LO_W = 4;  // only the low nibble of the function field is decoded

    localparam logic [CLASS_W-1:0] CLS_ADDR = 3'b000;
    localparam logic [CLASS_W-1:0] CLS_CMP  = 3'b001;
    localparam logic [CLASS_W-1:0] CLS_LOR  = 3'b010;
    localparam logic [CLASS_W-1:0] CLS_REG  = 3'b100;

    localparam logic [SEL_W-1:0] SEL_AND = 3'b000;
    localparam logic [SEL_W-1:0] SEL_OR  = 3'b001;
    localparam logic [SEL_W-1:0] SEL_ADD = 3'b010;
    localparam logic [SEL_W-1:0] SEL_SUB = 3'b110;
    localparam logic [SEL_W-1:0] SEL_SLT = 3'b111;

    // Low-nibble patterns that set select bit 0 for register-register work
    localparam int N_B0_TERMS = 2;
    localparam logic [FN_LO_W-1:0] B0_PAT [N_B0_TERMS] = '{4'b0101, 4'b1010};
endpackage

// File: rtl/alu_ctl_class.sv
// Module: decodes the operation class alone, for all non register-register work.
// Assumes the class value for register-register instructions is handled elsewhere;
// that value and all unused classes give the AND code here.
module alu_ctl_class
    import alu_ctl_pkg::*;
#(
    parameter int CW = CLASS_W,
    parameter int SW = SEL_W
) (
    input  logic [CW-1:0] cls,
    output logic [SW-1:0] sel
);
    // Purpose: map each fixed class to its operation.
    always_comb begin
        unique case (cls)
            CLS_ADDR: sel = SEL_ADD;
            CLS_CMP:  sel = SEL_SUB;
            CLS_LOR:  sel = SEL_OR;
            default:  sel = SEL_AND;
        endcase
    end
endmodule

// File: rtl/alu_ctl_fn.sv
// Module: sum-of-products decode of the function field's low nibble for
// register-register instructions. Assumes the caller drops function bits 5..4.
module alu_ctl_fn
    import alu_ctl_pkg::*;
#(
    parameter int LW = FN_LO_W,
    parameter int SW = SEL_W,
    parameter int NT = N_B0_TERMS
) (
    input  logic [LW-1:0] fn_lo,
    output logic [SW-1:0] sel
);
    logic [NT-1:0] b0_hit;

    // Purpose: one product term per pattern that sets bit 0.
    for (genvar t = 0; t < NT; t++) begin : g_b0
        assign b0_hit[t] = (fn_lo == B0_PAT[t]);
    end

    // Purpose: form the three select bits from their product terms.
    always_comb begin
        sel    = '0;
        sel[2] = ~fn_lo[2] & fn_lo[1] & ~fn_lo[0];
        sel[1] = ~fn_lo[2];
        sel[0] = |b0_hit;
    end
endmodule

// File: rtl/alu_ctl_dec.sv
// Module: top of the ALU operation select decoder. It chooses between the
// class-only decode and the function-field decode. Purely combinational.
// Assumes class 100 marks register-register instructions.
module alu_ctl_dec
    import alu_ctl_pkg::*;
#(
    parameter int CW = CLASS_W,
    parameter int FW = FN_W,
    parameter int SW = SEL_W
) (
    input  logic [CW-1:0] alu_class,
    input  logic [FW-1:0] fn_code,
    output logic [SW-1:0] alu_sel
);
    localparam int LW = FN_LO_W;

    logic [SW-1:0] cls_sel;
    logic [SW-1:0] fn_sel;
    logic          is_reg;
    logic          unused_fn_hi;

    assign unused_fn_hi = ^fn_code[FW-1:LW];

    alu_ctl_class #(.CW(CW), .SW(SW)) u_cls (
        .cls (alu_class),
        .sel (cls_sel)
    );

    alu_ctl_fn #(.LW(LW), .SW(SW), .NT(N_B0_TERMS)) u_fn (
        .fn_lo (fn_code[LW-1:0]),
        .sel   (fn_sel)
    );

    // Purpose: pick the function decode only for register-register work.
    always_comb begin
        is_reg  = (alu_class == CLS_REG);
        alu_sel = is_reg ? fn_sel : cls_sel;
    end
endmodule

// File: rtl/alu_ctl_dec_chk.sv
// Checker: immediate assertions on the decoder ports, bound into the top.
module alu_ctl_dec_chk
    import alu_ctl_pkg::*;
(
    input logic [2:0] alu_class,
    input logic [5:0] fn_code,
    input logic [2:0] alu_sel
);
    // Purpose: check the port relations whenever an input changes.
    always_comb begin
        if (alu_class == 3'b000) AST_CLASS_ADD: assert (alu_sel == 3'b010); // R1
        if (alu_class == 3'b001) AST_CLASS_SUB: assert (alu_sel == 3'b110); // R2
        if (alu_class == 3'b010) AST_CLASS_OR: assert (alu_sel == 3'b001); // R3
        if (alu_class[2] ^ alu_class[1] ^ alu_class[0] ? alu_class == 3'b111 : alu_class != 3'b000)
            AST_UNUSED_CLASS: assert (alu_class == 3'b100 || alu_sel == 3'b000); // R4
        if (alu_class == 3'b100 && fn_code[3:0] == 4'b1010)
            AST_SLT_SEL: assert (alu_sel == 3'b111); // R7
        if (alu_class == 3'b100)
            AST_REG_BIT1: assert (alu_sel[1] == ~fn_code[2]); // R9
    end
endmodule

bind alu_ctl_dec alu_ctl_dec_chk u_chk (
    .alu_class (alu_class),
    .fn_code   (fn_code),
    .alu_sel   (alu_sel)
);

// File: tb/sim_alu_ctl_dec.sv
module sim_alu_ctl_dec;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cls = 3'b000;
    logic [5:0] fn  = 6'b000000;
    logic [2:0] sel;
    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    alu_ctl_dec u0 (.alu_class(cls), .fn_code(fn), .alu_sel(sel));

    // entry = {class, function, expected}
    localparam int NV = 14;
    localparam logic [11:0] VEC [NV] = '{
        {3'b000, 6'b101010, 3'b010},  // R1
        {3'b001, 6'b100000, 3'b110},  // R2
        {3'b010, 6'b100010, 3'b001},  // R3
        {3'b011, 6'b101010, 3'b000},  // R4
        {3'b111, 6'b100101, 3'b000},  // R4
        {3'b100, 6'b100000, 3'b010},  // R5
        {3'b100, 6'b100010, 3'b110},  // R5
        {3'b100, 6'b100100, 3'b000},  // R6
        {3'b100, 6'b100101, 3'b001},  // R6
        {3'b100, 6'b101010, 3'b111},  // R7
        {3'b100, 6'b011010, 3'b111},  // R8
        {3'b100, 6'b000101, 3'b001},  // R8
        {3'b100, 6'b101101, 3'b000},  // R9
        {3'b100, 6'b100011, 3'b010}   // R9
    };

    function automatic logic [2:0] ref_sel(input logic [2:0] c, input logic [5:0] f);
        if (c == 3'b000) return 3'b010;
        if (c == 3'b001) return 3'b110;
        if (c == 3'b010) return 3'b001;
        if (c != 3'b100) return 3'b000;
        case (f[2:0])
            3'b010:  return f[3] ? 3'b111 : 3'b110;
            3'b101:  return f[3] ? 3'b000 : 3'b001;
            3'b100, 3'b110, 3'b111: return 3'b000;
            default: return 3'b010;
        endcase
    endfunction

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic check(input logic [2:0] c, input logic [5:0] f,
                         input logic [2:0] exp, input string req);
        @(negedge clk);
        cls = c;
        fn  = f;
        #1;
        n_chk++;
        if (sel !== exp) begin
            n_fail++;
            $display("FAIL %s class=%b fn=%b actual=%b expected=%b", req, c, f, sel, exp);
        end
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=20000 cycles", cycles);
            finish_up();
        end
    end

    initial begin
        // outputs during reset, inputs at zero: R1
        check(3'b000, 6'b000000, 3'b010, "R1");
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            string tag;
            case (VEC[i][11:9])
                3'b000: tag = "R1";
                3'b001: tag = "R2";
                3'b010: tag = "R3";
                3'b100: tag = "R5-R9";
                default: tag = "R4";
            endcase
            check(VEC[i][11:9], VEC[i][8:3], VEC[i][2:0], tag);
        end
        // exhaustive sweep against the reference model: R1 R2 R3 R4 R9
        for (int c = 0; c < 8; c++) begin
            for (int f = 0; f < 64; f++) begin
                check(3'(c), 6'(f), ref_sel(3'(c), 6'(f)), "R9");
            end
        end
        // R8: the upper function bits do not change the result
        for (int f = 0; f < 16; f++) begin
            for (int h = 0; h < 4; h++) begin
                check(3'b100, {2'(h), 4'(f)}, ref_sel(3'b100, {2'b10, 4'(f)}), "R8");
            end
        end
        // R7 corner: set-less-than after a non-register class with the same field
        check(3'b011, 6'b101010, 3'b000, "R4");
        check(3'b100, 6'b101010, 3'b111, "R7");
        done = 1'b1;
        finish_up();
    end
endmodule